// File: doc/BRIEF.md
# Divider Occupancy and Hi/Lo Interlock Tracker

This block models the timing of a single integer divider that is not pipelined. An issue stage raises a divide request tagged as narrow (32-bit) or wide (64-bit). The tracker accepts or refuses the request in the same cycle. It then follows the accepted divide through three phases: a short lead-in, a window in which the divider is held, and a write-back delay. No quotient is computed; only occupancy and timing are produced.

The divider is held only from the fourth cycle after issue. A new divide may therefore be accepted during the last cycles of the previous one's hold window, so the two windows sit back to back. A result-ready strobe fires on the latency cycle. A hi/lo write strobe follows a fixed number of cycles later. For the whole time a divide is in flight, an interlock output tells the issue logic to hold back hi/lo moves and any other hi/lo writers. A refused request is not stored. The issuer keeps the request raised until it is accepted.

Top module: `div_occ_tracker`

## Requirements
- R1: With no divide in flight, a request is accepted in the cycle it is raised: `div_accept_o` is 1 and `div_stall_o` is 0 in that cycle.
- R2: For a narrow divide (`div_wide_i` = 0) accepted in cycle t, `div_busy_o` is 1 in cycles t+4 through t+35 and 0 in cycles t+1 to t+3.
- R3: For a wide divide (`div_wide_i` = 1) accepted in cycle t, `div_busy_o` is 1 in cycles t+4 through t+67.
- R4: `div_done_o` is a one-cycle strobe in cycle t+36 (narrow) or t+68 (wide), which is the first cycle after the hold window.
- R5: `hilo_wr_o` is a one-cycle strobe in cycle t+40 (narrow) or t+72 (wide), four cycles after the done strobe.
- R6: `hilo_lock_o` is 1 in every cycle from t+1 up to and including the hi/lo write cycle, and 0 when no divide is in flight.
- R7: A request is refused while a divide is in its lead-in, or while its hold window extends beyond three cycles past the current cycle. A refused request raises `div_stall_o` and leaves all timing unchanged. The earliest accepted retry comes 32 (narrow) or 64 (wide) cycles after the previous issue.
- R8: A divide accepted at that earliest point begins its hold window in the cycle right after the previous window ends, so `div_busy_o` stays high without a gap. The previous divide's done and hi/lo write strobes still occur on time.
- R9: Reset, at any point, clears all in-flight state. Busy, done, hi/lo write, interlock, accept and stall are all 0 after reset while no request is raised.
- R10: `div_accept_o` and `div_stall_o` are never both 1, and both are 0 when `div_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_req_i | input | 1 | Divide issue request |
| div_wide_i | input | 1 | 1 = 64-bit divide, 0 = 32-bit divide |
| div_accept_o | output | 1 | Request accepted this cycle |
| div_stall_o | output | 1 | Request refused this cycle; issuer retries |
| div_busy_o | output | 1 | Divider held |
| div_done_o | output | 1 | Result-ready strobe on the latency cycle |
| hilo_wr_o | output | 1 | Hi/lo write strobe of the divide |
| hilo_lock_o | output | 1 | Interlock for hi/lo moves and other hi/lo writers |

## Verification
The bench builds the tracker with its default parameters: a 3-cycle lead-in, 32 and 64 hold cycles, and a 4-cycle write-back delay. This makes the exact 36/40 and 68/72 cycle figures visible at the ports. For each pair of narrow and wide widths, it issues a first divide and sweeps the offset of a second request over 1 to 70 cycles. This covers refusal in the lead-in, refusal in the hold window, the exact back-to-back acceptance point and requests after the divider goes idle. A separate case resets the block partway through a divide.

// File: rtl/div_occ_pkg.sv
package div_occ_pkg;
  typedef struct packed {
    logic vld;
    logic wide;
  } div_tag_t;
endpackage

// File: rtl/div_lead_pipe.sv
module div_lead_pipe
  import div_occ_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_tag_t tag_i,
  output div_tag_t tag_o,
  output logic     pend_o
);
  div_tag_t       stg_q [DEPTH];
  logic [DEPTH-1:0] vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    div_tag_t nxt;
    if (i == 0) begin : g_head
      assign nxt = tag_i;
    end else begin : g_body
      assign nxt = stg_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= nxt;
    end
    assign vld[i] = stg_q[i].vld;
  end

  assign tag_o  = stg_q[DEPTH-1];
  assign pend_o = |vld;
endmodule

// File: rtl/div_busy_ctr.sv
module div_busy_ctr #(
  parameter int unsigned NARROW_CYC = 32,
  parameter int unsigned WIDE_CYC   = 64,
  localparam int unsigned CW        = $clog2(WIDE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          wide_i,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  // a load wins over the final decrement: back-to-back hold windows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= wide_i ? CW'(WIDE_CYC) : CW'(NARROW_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/div_wb_delay.sv
module div_wb_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o,
  output logic pend_o
);
  logic [DEPTH-1:0] sr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else         sr_q[i] <= (i == 0) ? pulse_i : sr_q[(i == 0) ? 0 : i-1];
    end
  end

  assign pulse_o = sr_q[DEPTH-1];
  assign pend_o  = |sr_q;
endmodule

// File: rtl/div_occ_tracker.sv
module div_occ_tracker
  import div_occ_pkg::*;
#(
  parameter int unsigned LEAD_CYC   = 3,
  parameter int unsigned NARROW_CYC = 32,
  parameter int unsigned WIDE_CYC   = 64,
  parameter int unsigned WB_DLY     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_req_i,
  input  logic div_wide_i,
  output logic div_accept_o,
  output logic div_stall_o,
  output logic div_busy_o,
  output logic div_done_o,
  output logic hilo_wr_o,
  output logic hilo_lock_o
);
  localparam int unsigned CW = $clog2(WIDE_CYC + 1);

  div_tag_t      issue_tag, lead_tag;
  logic          lead_pend, busy_last, wb_pend;
  logic [CW-1:0] hold_cnt;
  logic          done_q;

  // free if nothing in lead-in and the hold ends by the cycle before ours starts
  assign div_accept_o = div_req_i && !lead_pend && (hold_cnt <= CW'(LEAD_CYC + 1));
  assign div_stall_o  = div_req_i && !div_accept_o;

  assign issue_tag.vld  = div_accept_o;
  assign issue_tag.wide = div_wide_i;

  div_lead_pipe #(.DEPTH(LEAD_CYC)) i_lead (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (issue_tag),
    .tag_o  (lead_tag),
    .pend_o (lead_pend)
  );

  div_busy_ctr #(.NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lead_tag.vld),
    .wide_i (lead_tag.wide),
    .cnt_o  (hold_cnt),
    .busy_o (div_busy_o),
    .last_o (busy_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= busy_last;
  end

  div_wb_delay #(.DEPTH(WB_DLY)) i_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (done_q),
    .pulse_o (hilo_wr_o),
    .pend_o  (wb_pend)
  );

  assign div_done_o  = done_q;
  assign hilo_lock_o = lead_pend || div_busy_o || done_q || wb_pend;
endmodule

// File: rtl/div_occ_checker.sv
module div_occ_checker #(
  parameter int unsigned WB_DLY = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic div_req_i,
  input logic div_accept_o,
  input logic div_stall_o,
  input logic div_busy_o,
  input logic div_done_o,
  input logic hilo_wr_o,
  input logic hilo_lock_o
);
  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(div_accept_o && div_stall_o));

  assert_stall_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_stall_o |-> div_req_i);

  assert_no_double_issue_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_accept_o |=> !div_accept_o);

  assert_lock_after_issue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_accept_o |=> hilo_lock_o);

  assert_busy_locks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy_o |-> hilo_lock_o);

  assert_done_after_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done_o |-> $past(div_busy_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done_o |=> !div_done_o);

  assert_wr_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hilo_wr_o |-> $past(div_done_o, WB_DLY));
endmodule

bind div_occ_tracker div_occ_checker #(.WB_DLY(WB_DLY)) i_div_occ_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .div_req_i    (div_req_i),
  .div_accept_o (div_accept_o),
  .div_stall_o  (div_stall_o),
  .div_busy_o   (div_busy_o),
  .div_done_o   (div_done_o),
  .hilo_wr_o    (hilo_wr_o),
  .hilo_lock_o  (hilo_lock_o)
);

// File: tb/test_div_occ_tracker.sv
`timescale 1ns/1ps
module test_div_occ_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic wide = 1'b0;
  logic accept, stall, busy, done, hwr, lock;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  div_occ_tracker i_div_occ_tracker (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .div_req_i    (req),
    .div_wide_i   (wide),
    .div_accept_o (accept),
    .div_stall_o  (stall),
    .div_busy_o   (busy),
    .div_done_o   (done),
    .hilo_wr_o    (hwr),
    .hilo_lock_o  (lock)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp, input int k);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, what, k, act, exp);
    end
  endtask

  function automatic bit in_rng(int k, int lo, int hi);
    return (k >= lo) && (k <= hi);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    #1;
    chk(tag, "busy", busy, 1'b0, -1);
    chk(tag, "done", done, 1'b0, -1);
    chk(tag, "hilo_wr", hwr, 1'b0, -1);
    chk(tag, "lock", lock, 1'b0, -1);
    chk(tag, "accept", accept, 1'b0, -1);
    chk(tag, "stall", stall, 1'b0, -1);
  endtask

  // first divide in cycle 0, second raised at cycle g and retried until accepted
  task automatic run_case(input int g, input bit w1, input bit w2);
    int l1, l2, a2, last;
    string btag;
    l1 = w1 ? 64 : 32;
    l2 = w2 ? 64 : 32;
    a2 = (g > l1) ? g : l1;
    last = a2 + l2 + 12;
    btag = w1 ? "R3" : "R2";
    do_reset();
    for (int k = 0; k <= last; k++) begin
      bit r;
      @(negedge clk);
      r = (k == 0) || in_rng(k, g, a2);
      req  = r;
      wide = (k == 0) ? w1 : w2;
      #1;
      chk((k == 0) ? "R1" : "R7", "accept", accept, (k == 0) || (k == a2), k);
      chk(r ? "R7" : "R10", "stall", stall, in_rng(k, g, a2 - 1), k);
      chk(btag, "busy", busy, in_rng(k, 4, 3 + l1) || in_rng(k, a2 + 4, a2 + 3 + l2), k);
      chk("R4", "done", done, (k == l1 + 4) || (k == a2 + l2 + 4), k);
      chk("R5", "hilo_wr", hwr, (k == l1 + 8) || (k == a2 + l2 + 8), k);
      chk("R6", "lock", lock, in_rng(k, 1, l1 + 8) || in_rng(k, a2 + 1, a2 + l2 + 8), k);
      if (g <= l1 && (k == l1 + 3 || k == l1 + 4))
        chk("R8", "busy seam", busy, 1'b1, k);
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    do_reset();
    check_idle("R9");
    for (int w1 = 0; w1 < 2; w1++)
      for (int w2 = 0; w2 < 2; w2++)
        for (int g = 1; g <= 70; g++)
          run_case(g, w1[0], w2[0]);
    // reset partway through a wide divide
    do_reset();
    @(negedge clk);
    req = 1'b1;
    wide = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (80) begin
      @(negedge clk);
      #1;
      chk("R9", "hilo_wr after reset", hwr, 1'b0, -1);
      chk("R9", "done after reset", done, 1'b0, -1);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule